// File: doc/BRIEF.md
# ATM transmit cell processor

This block takes ATM cells from a user, one byte per write, and holds them in a small queue with room for four cells. Downstream logic that builds the payload envelope asks for one byte at a time. The block answers every request with one byte, so it keeps up a continuous 53-byte cell stream. When the queue holds no complete cell at the moment a new cell must start, the block sends an idle cell in its place, so the stream never stalls.

For every outgoing cell the block can do two things, and each can be switched off separately. It can replace the fifth header byte with a freshly computed header check sequence. It can pass the 48 payload bytes through a self-synchronising scrambler. The four leading header bytes always leave unscrambled.

Top module: `atm_tx_cellproc`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `overflow` are 0. After reset the scrambler history is all zeros and the byte index is at the start of a cell.
- R2: A clock edge with `out_req` high makes `out_valid` high after that edge, carrying exactly one byte. An edge with `out_req` low makes `out_valid` low. Bytes are grouped into 53-byte cells, and `out_soc` is high only with the first byte of each cell.
- R3: If, when a cell starts, the queue holds fewer than one complete cell, an idle cell is sent. Its header is 00 00 00 01, its fifth byte is always 0x52, and its 48 payload bytes are 0x6A before scrambling.
- R4: Complete user cells are sent in write order, and their four leading header bytes are sent unchanged. A cell becomes eligible at the first cell start after the edge that wrote its 53rd byte. A partly written cell is never sent.
- R5: With `hcs_en` high, the fifth byte is the CRC-8 of the four header bytes, XORed with 0x55. The CRC uses generator x^8+x^2+x+1, initial value 0 and MSB first. With `hcs_en` low, the fifth byte is sent as written.
- R6: With `scr_en` high, each payload bit, taken MSB first, is XORed with the output bit sent 43 payload bits earlier. The scrambler history does not advance during the five header bytes.
- R7: With `scr_en` low, payload bytes are sent as written and the scrambler history is frozen.
- R8: The queue holds four complete cells. A write while four complete cells are held is dropped, and `overflow` goes high at the next edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one cell byte |
| wr_byte | input | 8 | Cell byte being written |
| hcs_en | input | 1 | 1: insert computed header check byte |
| scr_en | input | 1 | 1: scramble payload bytes |
| out_req | input | 1 | Downstream requests one byte |
| out_valid | output | 1 | Output byte is present |
| out_byte | output | 8 | Output cell byte |
| out_soc | output | 1 | First byte of a cell |
| overflow | output | 1 | Sticky flag: a write was dropped because the queue was full |

## Verification
An output byte appears one clock after the edge that sampled `out_req`. The overflow flag rises one clock after the dropped write. A newly completed cell can be picked at the next cell start after the edge that wrote its last byte. The bench model updates at the same rising edge as the design, using values taken before that edge. It compares each predicted byte, start marker and flag at the following falling edge, so every check looks exactly one register stage after its stimulus.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int CELL_BYTES   = 53;
  localparam int HDR_BYTES    = 4;
  localparam int SCR_LEN      = 43;
  localparam logic [7:0] CRC_POLY     = 8'h07;
  localparam logic [7:0] HCS_COSET    = 8'h55;
  localparam logic [7:0] IDLE_PAYLOAD = 8'h6A;

  typedef struct packed {
    logic [SCR_LEN-1:0] st;
    logic [7:0]         q;
  } scr_res_t;

  // One byte of CRC-8, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction

  // Self-synchronising scrambler over one byte, MSB first
  function automatic scr_res_t scr_step(input logic [SCR_LEN-1:0] st, input logic [7:0] d);
    scr_res_t r;
    logic     b;
    r.st = st;
    r.q  = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      b      = d[i] ^ r.st[SCR_LEN-1];
      r.q[i] = b;
      r.st   = {r.st[SCR_LEN-2:0], b};
    end
    return r;
  endfunction

  function automatic logic [7:0] idle_hdr_byte(input int idx);
    return (idx == HDR_BYTES - 1) ? 8'h01 : 8'h00;
  endfunction

  // Byte idx of the idle cell before header check and scrambling
  function automatic logic [7:0] idle_byte(input int idx);
    logic [7:0] c;
    if (idx < HDR_BYTES) return idle_hdr_byte(idx);
    if (idx == HDR_BYTES) begin
      c = 8'h00;
      for (int k = 0; k < HDR_BYTES; k++) c = crc8_step(c, idle_hdr_byte(k));
      return c ^ HCS_COSET;
    end
    return IDLE_PAYLOAD;
  endfunction
endpackage

// File: rtl/atm_tx_cell_fifo.sv
module atm_tx_cell_fifo
  import atm_tx_pkg::*;
#(
  parameter int CELL_BYTES  = atm_tx_pkg::CELL_BYTES,
  parameter int DEPTH_CELLS = 4,
  localparam int OFF_W      = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic [OFF_W-1:0] rd_idx,
  input  logic             rd_release,
  output logic [7:0]       rd_byte,
  output logic             cell_ready,
  output logic             overflow
);
  localparam int SLOT_W = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int CNT_W  = $clog2(DEPTH_CELLS + 1);
  localparam int TOTAL  = CELL_BYTES * DEPTH_CELLS;
  localparam int ADDR_W = $clog2(TOTAL);
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH_CELLS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH_CELLS);

  logic [7:0]        mem [TOTAL];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [OFF_W-1:0]  wr_off;
  logic [CNT_W-1:0]  ccnt;

  // Named events for assertions
  logic full, wr_accept, wr_commit, wr_drop;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] s);
    return (s == LAST_SLOT) ? '0 : s + SLOT_W'(1);
  endfunction

  always_comb begin
    full       = (ccnt == FULL_CNT);
    wr_accept  = wr_en && !full;
    wr_drop    = wr_en && full;
    wr_commit  = wr_accept && (wr_off == LAST_OFF);
    wr_addr    = ADDR_W'(wr_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(wr_off);
    rd_addr    = ADDR_W'(rd_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);
    rd_byte    = mem[rd_addr];
    cell_ready = (ccnt != '0);
  end

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wr_addr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot  <= '0;
      rd_slot  <= '0;
      wr_off   <= '0;
      ccnt     <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_accept) wr_off <= wr_commit ? '0 : wr_off + OFF_W'(1);
      if (wr_commit) wr_slot <= bump(wr_slot);
      if (rd_release) rd_slot <= bump(rd_slot);
      ccnt <= ccnt + CNT_W'(wr_commit) - CNT_W'(rd_release);
      if (wr_drop) overflow <= 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> overflow);
  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt <= FULL_CNT);
  assert_release_has_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release |-> cell_ready);
endmodule

// File: rtl/atm_tx_cell_sched.sv
module atm_tx_cell_sched
  import atm_tx_pkg::*;
#(
  parameter int CELL_BYTES = atm_tx_pkg::CELL_BYTES,
  localparam int OFF_W     = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             cell_ready,
  output logic [OFF_W-1:0] idx,
  output logic             cur_idle,
  output logic             rd_release
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(CELL_BYTES - 1);

  logic idle_r;
  logic cell_start, cell_end;

  always_comb begin
    cell_start = (idx == '0);
    cell_end   = (idx == LAST);
    cur_idle   = cell_start ? !cell_ready : idle_r;
    rd_release = step && cell_end && !cur_idle;
  end

  // R1: reset puts the index at a cell start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      idle_r <= 1'b1;
    end else if (step) begin
      idx <= cell_end ? '0 : idx + OFF_W'(1);
      if (cell_start) idle_r <= !cell_ready;
    end
  end

  assert_idx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cell_end) |=> (idx == '0));
  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx));
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
endmodule

// File: rtl/atm_tx_cell_xform.sv
module atm_tx_cell_xform
  import atm_tx_pkg::*;
#(
  parameter int CELL_BYTES = atm_tx_pkg::CELL_BYTES,
  localparam int OFF_W     = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [OFF_W-1:0] idx,
  input  logic             cur_idle,
  input  logic [7:0]       fifo_byte,
  input  logic             hcs_en,
  input  logic             scr_en,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_soc
);
  localparam logic [OFF_W-1:0] HCS_IDX = OFF_W'(HDR_BYTES);

  logic [7:0]         crc;
  logic [SCR_LEN-1:0] scr_st;
  logic [7:0]         raw, nxt, crc_nxt;
  logic               in_hdr, at_hcs, in_pay;
  scr_res_t           scr_r;

  always_comb begin
    raw     = cur_idle ? idle_byte(int'(idx)) : fifo_byte;
    in_hdr  = (idx < HCS_IDX);
    at_hcs  = (idx == HCS_IDX);
    in_pay  = (idx > HCS_IDX);
    crc_nxt = crc8_step((idx == '0) ? 8'h00 : crc, raw);
    scr_r   = scr_step(scr_st, raw);
    nxt     = raw;
    if (at_hcs && hcs_en)      nxt = crc ^ HCS_COSET;
    else if (in_pay && scr_en) nxt = scr_r.q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc       <= '0;
      scr_st    <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_soc   <= 1'b0;
    end else begin
      out_valid <= step;
      out_soc   <= step && (idx == '0);
      if (step) begin
        out_byte <= nxt;
        if (in_hdr) crc <= crc_nxt;
        if (in_pay && scr_en) scr_st <= scr_r.st;
      end
    end
  end

  assert_req_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> out_valid);
  assert_noreq_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !out_valid);
  assert_hdr_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !in_pay) |=> $stable(scr_st));
  assert_scr_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_en |=> $stable(scr_st));
  assert_hcs_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_hcs && !hcs_en) |=> (out_byte == $past(raw)));
endmodule

// File: rtl/atm_tx_cellproc.sv
module atm_tx_cellproc
  import atm_tx_pkg::*;
#(
  parameter int CELL_BYTES  = atm_tx_pkg::CELL_BYTES,
  parameter int DEPTH_CELLS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       hcs_en,
  input  logic       scr_en,
  input  logic       out_req,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_soc,
  output logic       overflow
);
  localparam int OFF_W = $clog2(CELL_BYTES);

  logic [OFF_W-1:0] idx;
  logic             cur_idle, rd_release, cell_ready;
  logic [7:0]       fifo_byte;

  atm_tx_cell_fifo #(.CELL_BYTES(CELL_BYTES), .DEPTH_CELLS(DEPTH_CELLS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_idx(idx), .rd_release(rd_release), .rd_byte(fifo_byte),
    .cell_ready(cell_ready), .overflow(overflow)
  );

  atm_tx_cell_sched #(.CELL_BYTES(CELL_BYTES)) u_sched (
    .clk(clk), .rst_n(rst_n), .step(out_req), .cell_ready(cell_ready),
    .idx(idx), .cur_idle(cur_idle), .rd_release(rd_release)
  );

  atm_tx_cell_xform #(.CELL_BYTES(CELL_BYTES)) u_xform (
    .clk(clk), .rst_n(rst_n), .step(out_req), .idx(idx), .cur_idle(cur_idle),
    .fifo_byte(fifo_byte), .hcs_en(hcs_en), .scr_en(scr_en),
    .out_valid(out_valid), .out_byte(out_byte), .out_soc(out_soc)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !overflow));
  assert_soc_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);
endmodule

// File: tb/sim_atm_tx_cellproc.sv
`timescale 1ns/1ps
module sim_atm_tx_cellproc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       hcs_en = 1'b1;
  logic       scr_en = 1'b1;
  logic       out_req = 1'b0;
  logic       out_valid, out_soc, overflow;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  int req_mode = 0;

  always #4 clk = ~clk;

  atm_tx_cellproc u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
    .hcs_en(hcs_en), .scr_en(scr_en), .out_req(out_req),
    .out_valid(out_valid), .out_byte(out_byte), .out_soc(out_soc),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model state
  logic [7:0]  cellq[$];
  logic [7:0]  partial[$];
  logic [7:0]  hdr[4];
  logic [63:0] hist;
  int          m_idx;
  bit          m_idle, m_ovf, cmp;
  bit          e_v, e_soc;
  logic [7:0]  e_b;
  string       e_tag;

  function automatic logic [7:0] ref_hcs(input logic [7:0] h0, input logic [7:0] h1,
                                         input logic [7:0] h2, input logic [7:0] h3);
    logic [39:0] v;
    v = {h0, h1, h2, h3, 8'h00};
    for (int b = 39; b >= 8; b--)
      if (v[b]) v = v ^ (40'h107 << (b - 8));
    return v[7:0] ^ 8'h55;
  endfunction

  always @(posedge clk) begin
    int         full_cells;
    logic [7:0] raw, val;
    logic       o;
    if (!rst_n) begin
      cellq.delete(); partial.delete();
      hist = '0; m_idx = 0; m_idle = 1; m_ovf = 0;
      e_v = 0; e_soc = 0; e_b = 0; cmp = 0; e_tag = "R1";
    end else begin
      full_cells = cellq.size() / 53;
      if (out_req) begin
        if (m_idx == 0) m_idle = (cellq.size() < 53);
        if (m_idle) begin
          if (m_idx < 3) raw = 8'h00;
          else if (m_idx == 3) raw = 8'h01;
          else if (m_idx == 4) raw = 8'h52;
          else raw = 8'h6A;
        end else raw = cellq[m_idx];
        val = raw;
        if (m_idx < 4) begin
          hdr[m_idx] = raw;
          e_tag = m_idle ? "R3" : "R4";
        end else if (m_idx == 4) begin
          if (hcs_en) val = ref_hcs(hdr[0], hdr[1], hdr[2], hdr[3]);
          e_tag = (m_idle && !hcs_en) ? "R3" : "R5";
        end else if (scr_en) begin
          for (int b = 7; b >= 0; b--) begin
            o = raw[b] ^ hist[42];
            val[b] = o;
            hist = {hist[62:0], o};
          end
          e_tag = "R6";
        end else e_tag = m_idle ? "R3" : "R7";
        e_v = 1; e_b = val; e_soc = (m_idx == 0);
        if (m_idx == 52) begin
          m_idx = 0;
          if (!m_idle) repeat (53) void'(cellq.pop_front());
        end else m_idx++;
      end else begin
        e_v = 0; e_soc = 0;
      end
      if (wr_en) begin
        if (full_cells == 4) m_ovf = 1;
        else begin
          partial.push_back(wr_byte);
          if (partial.size() == 53) begin
            foreach (partial[i]) cellq.push_back(partial[i]);
            partial.delete();
          end
        end
      end
      cmp = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp && rst_n) begin
      chk(out_valid == e_v, "R2", "out_valid", int'(out_valid), int'(e_v));
      if (e_v) begin
        chk(out_soc == e_soc, "R2", "out_soc", int'(out_soc), int'(e_soc));
        chk(out_byte == e_b, e_tag, "out_byte", int'(out_byte), int'(e_b));
      end
      chk(overflow == m_ovf, "R8", "overflow", int'(overflow), int'(m_ovf));
    end
  end

  task automatic write_cell(input int seed, input bit gap);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_byte = 8'(seed * 7 + i * 13);
      if (gap) begin
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_for(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk);
        case (req_mode)
          0: out_req = 1'b0;
          1: out_req = 1'b1;
          default: out_req = 1'($urandom_range(0, 1));
        endcase
      end
    join_none
    idle_for(5);
    chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(overflow == 1'b0, "R1", "reset overflow", int'(overflow), 0);
    rst_n = 1'b1;
    req_mode = 1;
    idle_for(120);                       // R3 idle cells, R6 scrambled
    write_cell(16, 1'b1);                // R4 partial cell not sent
    idle_for(120);
    req_mode = 0;
    idle_for(60);
    for (int c = 0; c < 5; c++) write_cell(32 + c, 1'b0);   // R8 fifth dropped
    idle_for(10);
    req_mode = 2;
    idle_for(700);
    hcs_en = 1'b0; scr_en = 1'b0;        // R5 and R7 bypass
    write_cell(50, 1'b0);
    write_cell(51, 1'b1);
    req_mode = 1;
    idle_for(200);
    hcs_en = 1'b1; scr_en = 1'b0;
    write_cell(60, 1'b0);
    idle_for(150);
    hcs_en = 1'b0; scr_en = 1'b1;
    write_cell(61, 1'b0);
    idle_for(150);
    hcs_en = 1'b1; scr_en = 1'b1;
    for (int c = 0; c < 6; c++) write_cell(70 + c, 1'b0);
    req_mode = 2;
    idle_for(800);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule